// File: doc/BRIEF.md
# Transactional Line Set Tracker

This block sits beside the private L1 data cache of a core that runs best-effort hardware transactions. For every cache line it holds two flags. One marks that the running transaction has read the line. The other marks that the transaction has written it. It watches CPU accesses, line evictions and incoming coherence requests.

From those flags it decides three things. It decides when the old contents of a dirty line must be copied to L2 before a transactional store may proceed. It decides when the transaction has lost its isolation and must abort. It decides which lines must be dropped when an abort happens. The tag array, the data array and the directory protocol are outside the block. They reach it through simple request and response ports that carry a set number and a way number.

Conflicts are detected eagerly and the requester always wins: a remote request that collides with the local footprint aborts the local transaction. A commit or an abort wipes every flag in one cycle. An abort also reports a two-bit cause code and a one-cycle mask of the lines the transaction had written, so that those lines can be invalidated.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset no line is tracked, and abort_pulse, abort_cause, inval_mask, acc_done and backup_req are all zero.
- R2: An accepted transactional load sets the read flag of its line. A later incoming read (snoop_write=0) to that line does not abort. A later incoming write or invalidate (snoop_write=1) aborts with cause 2'b00.
- R3: An accepted transactional store to a line that is not Modified sets the write flag of its line. acc_done pulses one cycle after acceptance. Any later incoming request to that line aborts with cause 2'b00.
- R4: Non-transactional loads and stores set no flag. acc_done still pulses one cycle after acceptance.
- R5: A transactional store to a Modified line (acc_line_mod=1) whose write flag is clear starts a backup. From the next cycle, backup_req stays high with backup_set/backup_way naming the line and acc_ready stays low, until backup_ack is sampled high. One cycle after that, acc_done pulses and the write flag is set. A store to a line whose write flag is already set starts no backup.
- R6: Evicting a line whose read or write flag is set aborts with cause 2'b01 (evict_incl=0) or 2'b10 (evict_incl=1). Evicting an untracked line has no effect.
- R7: abort_req aborts with cause 2'b11.
- R8: An abort raises abort_pulse for one cycle, one cycle after its trigger. In that same cycle inval_mask holds the write flags as they stood before the abort, with line index = set*WAYS + way. At all other times inval_mask is zero. All flags are clear afterwards.
- R9: commit clears every flag without an abort pulse and with inval_mask zero.
- R10: A clear (commit or abort) and a transactional access in the same cycle resolve with the clear first. The access then marks its line for the next transaction.
- R11: When several abort triggers coincide, the reported cause is the first of this list: conflict, eviction, explicit.
- R12: An abort while a backup is pending drops the store. backup_req falls, no acc_done follows, and the line's write flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | CPU access request |
| acc_ready | output | 1 | Access accepted this cycle when high (low while a backup is pending) |
| acc_txn | input | 1 | Access belongs to the running transaction |
| acc_store | input | 1 | 1 store, 0 load |
| acc_line_mod | input | 1 | Target line is currently in Modified state |
| acc_set | input | SET_W | Set of the accessed line |
| acc_way | input | WAY_W | Way of the accessed line |
| acc_done | output | 1 | Access completed (one-cycle pulse) |
| snoop_valid | input | 1 | Incoming coherence request hits a local line |
| snoop_write | input | 1 | 1 write or invalidate, 0 read |
| snoop_set | input | SET_W | Set of the snooped line |
| snoop_way | input | WAY_W | Way of the snooped line |
| evict_valid | input | 1 | A line is being evicted |
| evict_incl | input | 1 | Eviction forced by L2 inclusion |
| evict_set | input | SET_W | Set of the evicted line |
| evict_way | input | WAY_W | Way of the evicted line |
| commit | input | 1 | Transaction commits |
| abort_req | input | 1 | Explicit abort request |
| backup_req | output | 1 | Old line data must be written to L2 |
| backup_set | output | SET_W | Set of the line being backed up |
| backup_way | output | WAY_W | Way of the line being backed up |
| backup_ack | input | 1 | L2 has accepted the backup data |
| abort_pulse | output | 1 | Transaction aborted (one-cycle pulse) |
| abort_cause | output | 2 | 00 conflict, 01 L1 eviction, 10 inclusion eviction, 11 explicit |
| inval_mask | output | LINES | Lines to invalidate on abort, bit set*WAYS+way |

## Verification
A flag stuck or lost inside the array stays hidden until the line is probed. It shows at the ports only when a later snoop or eviction to that line aborts, or fails to abort, one cycle after the probe. It also shows on the next abort, because inval_mask exposes the whole write set at once. The bench therefore follows each marking access with probes and explicit aborts, so that every stored flag is read back through the ports within a few cycles. A wrong backup state shows as backup_req, acc_ready or acc_done out of step with backup_ack, on the cycle right after the acknowledge.

// File: rtl/txn_tracker_pkg.sv
package txn_tracker_pkg;

   typedef enum logic [1:0] {
      CAUSE_CONFLICT   = 2'b00,
      CAUSE_L1_EVICT   = 2'b01,
      CAUSE_INCL_EVICT = 2'b10,
      CAUSE_EXPLICIT   = 2'b11
   } abort_cause_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/txn_flag_store.sv
// One read flag and one write flag per line, flash-cleared together.
module txn_flag_store #(
   parameter int LINES = 512,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rd_mark_en,
   input  logic [IDX_W-1:0] rd_mark_idx,
   input  logic             wr_mark_en,
   input  logic [IDX_W-1:0] wr_mark_idx,
   output logic [LINES-1:0] rd_flags,
   output logic [LINES-1:0] wr_flags
);

   for (genvar gi = 0; gi < LINES; gi++) begin : g_line
      logic rd_hit;
      logic wr_hit;

      assign rd_hit = rd_mark_en && (rd_mark_idx == IDX_W'(gi));
      assign wr_hit = wr_mark_en && (wr_mark_idx == IDX_W'(gi));

      // clear first, then the mark of the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_flags[gi] <= 1'b0;
            wr_flags[gi] <= 1'b0;
         end else begin
            rd_flags[gi] <= (rd_flags[gi] & ~clr) | rd_hit;
            wr_flags[gi] <= (wr_flags[gi] & ~clr) | wr_hit;
         end
      end
   end

endmodule

// File: rtl/txn_abort_detect.sv
// Combinational abort decision with fixed cause priority.
module txn_abort_detect
   import txn_tracker_pkg::*;
#(
   parameter int LINES = 512,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0] rd_flags,
   input  logic [LINES-1:0] wr_flags,
   input  logic             snoop_valid,
   input  logic             snoop_write,
   input  logic [IDX_W-1:0] snoop_idx,
   input  logic             evict_valid,
   input  logic             evict_incl,
   input  logic [IDX_W-1:0] evict_idx,
   input  logic             abort_req,
   output logic             abort_now,
   output abort_cause_e     cause
);

   logic snoop_rd_hit;
   logic snoop_wr_hit;
   logic conflict;
   logic evict_tracked;

   assign snoop_rd_hit  = rd_flags[snoop_idx];
   assign snoop_wr_hit  = wr_flags[snoop_idx];
   // a remote read only collides with local writes
   assign conflict      = snoop_valid && (snoop_wr_hit || (snoop_write && snoop_rd_hit));
   assign evict_tracked = evict_valid && (rd_flags[evict_idx] || wr_flags[evict_idx]);

   assign abort_now = conflict || evict_tracked || abort_req;

   always_comb begin
      if (conflict)           cause = CAUSE_CONFLICT;
      else if (evict_tracked) cause = evict_incl ? CAUSE_INCL_EVICT : CAUSE_L1_EVICT;
      else                    cause = CAUSE_EXPLICIT;
   end

endmodule

// File: rtl/txn_backup_ctrl.sv
// Holds one store while its line's old data travels to L2.
module txn_backup_ctrl #(
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             ack,
   input  logic             kill,
   output logic             busy,
   output logic [IDX_W-1:0] line_idx,
   output logic             finish
);

   typedef enum logic {BK_IDLE, BK_WAIT} bk_state_e;

   bk_state_e state_q;
   bk_state_e state_d;

   assign busy   = (state_q == BK_WAIT);
   assign finish = busy && ack && !kill;

   always_comb begin
      state_d = state_q;
      case (state_q)
         BK_IDLE: if (start)         state_d = BK_WAIT;
         BK_WAIT: if (kill || ack)   state_d = BK_IDLE;
         default:                    state_d = BK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= BK_IDLE;
         line_idx <= '0;
      end else begin
         state_q <= state_d;
         if (start && !busy) line_idx <= start_idx;
      end
   end

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
   import txn_tracker_pkg::*;
#(
   parameter  int LINE_BYTES  = 64,
   parameter  int CACHE_BYTES = 32768,
   parameter  int WAYS        = 4,
   localparam int SETS        = CACHE_BYTES / (LINE_BYTES * WAYS),
   localparam int LINES       = SETS * WAYS,
   localparam int SET_W       = $clog2(SETS),
   localparam int WAY_W       = $clog2(WAYS),
   localparam int IDX_W       = SET_W + WAY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   output logic             acc_ready,
   input  logic             acc_txn,
   input  logic             acc_store,
   input  logic             acc_line_mod,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   output logic             acc_done,
   input  logic             snoop_valid,
   input  logic             snoop_write,
   input  logic [SET_W-1:0] snoop_set,
   input  logic [WAY_W-1:0] snoop_way,
   input  logic             evict_valid,
   input  logic             evict_incl,
   input  logic [SET_W-1:0] evict_set,
   input  logic [WAY_W-1:0] evict_way,
   input  logic             commit,
   input  logic             abort_req,
   output logic             backup_req,
   output logic [SET_W-1:0] backup_set,
   output logic [WAY_W-1:0] backup_way,
   input  logic             backup_ack,
   output logic             abort_pulse,
   output logic [1:0]       abort_cause,
   output logic [LINES-1:0] inval_mask
);

   // ---------------- elaboration checks ----------------
   if (!is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (!is_pow2(LINE_BYTES)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (CACHE_BYTES % (LINE_BYTES * WAYS) != 0 || !is_pow2(SETS) || SETS < 2) begin : g_bad_geom
      $error("cache geometry must give a power-of-two set count of at least 2");
   end

   // ---------------- line indices: {set, way} = set*WAYS+way ----------------
   logic [IDX_W-1:0] acc_idx;
   logic [IDX_W-1:0] snoop_idx;
   logic [IDX_W-1:0] evict_idx;

   assign acc_idx   = {acc_set, acc_way};
   assign snoop_idx = {snoop_set, snoop_way};
   assign evict_idx = {evict_set, evict_way};

   // ---------------- flag storage ----------------
   logic [LINES-1:0] rd_flags;
   logic [LINES-1:0] wr_flags;
   logic             flags_clr;
   logic             rd_mark_en;
   logic             wr_mark_en;
   logic [IDX_W-1:0] wr_mark_idx;

   txn_flag_store #(
      .LINES (LINES),
      .IDX_W (IDX_W)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (flags_clr),
      .rd_mark_en  (rd_mark_en),
      .rd_mark_idx (acc_idx),
      .wr_mark_en  (wr_mark_en),
      .wr_mark_idx (wr_mark_idx),
      .rd_flags    (rd_flags),
      .wr_flags    (wr_flags)
   );

   // ---------------- abort decision ----------------
   logic         abort_now;
   abort_cause_e cause_now;

   txn_abort_detect #(
      .LINES (LINES),
      .IDX_W (IDX_W)
   ) u_detect (
      .rd_flags    (rd_flags),
      .wr_flags    (wr_flags),
      .snoop_valid (snoop_valid),
      .snoop_write (snoop_write),
      .snoop_idx   (snoop_idx),
      .evict_valid (evict_valid),
      .evict_incl  (evict_incl),
      .evict_idx   (evict_idx),
      .abort_req   (abort_req),
      .abort_now   (abort_now),
      .cause       (cause_now)
   );

   // ---------------- backup of old dirty data ----------------
   logic             bk_busy;
   logic             bk_finish;
   logic             bk_start;
   logic [IDX_W-1:0] bk_idx;

   txn_backup_ctrl #(
      .IDX_W (IDX_W)
   ) u_backup (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (bk_start),
      .start_idx (acc_idx),
      .ack       (backup_ack),
      .kill      (abort_now),
      .busy      (bk_busy),
      .line_idx  (bk_idx),
      .finish    (bk_finish)
   );

   // ---------------- access handling ----------------
   logic accept;
   logic txn_load;
   logic txn_store;
   logic wr_after_clr;

   assign flags_clr    = abort_now || commit;
   assign accept       = acc_valid && !bk_busy;
   assign txn_load     = accept && acc_txn && !acc_store;
   assign txn_store    = accept && acc_txn && acc_store;
   // the write flag the store sees belongs to the transaction after any clear
   assign wr_after_clr = wr_flags[acc_idx] && !flags_clr;
   assign bk_start     = txn_store && acc_line_mod && !wr_after_clr;

   assign rd_mark_en  = txn_load;
   assign wr_mark_en  = (txn_store && !bk_start) || bk_finish;
   assign wr_mark_idx = bk_finish ? bk_idx : acc_idx;

   assign acc_ready  = !bk_busy;
   assign backup_req = bk_busy;
   assign backup_set = bk_idx[IDX_W-1:WAY_W];
   assign backup_way = bk_idx[WAY_W-1:0];

   // ---------------- registered results ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_pulse <= 1'b0;
         abort_cause <= 2'b00;
         inval_mask  <= '0;
         acc_done    <= 1'b0;
      end else begin
         abort_pulse <= abort_now;
         abort_cause <= abort_now ? cause_now : CAUSE_CONFLICT;
         inval_mask  <= abort_now ? wr_flags : '0;
         acc_done    <= (accept && !bk_start) || bk_finish;
      end
   end

endmodule

// File: rtl/txn_set_tracker_chk.sv
module txn_set_tracker_chk #(
   parameter int LINES = 512
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_ready,
   input logic             acc_done,
   input logic             snoop_valid,
   input logic             evict_valid,
   input logic             evict_incl,
   input logic             abort_req,
   input logic             backup_req,
   input logic             abort_pulse,
   input logic [1:0]       abort_cause,
   input logic [LINES-1:0] inval_mask
);

   // R5: no new access is taken while old data is in flight
   a_r5_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      backup_req |-> !acc_ready);

   // R5 / R12: a backup ends either in completion or in an abort
   a_r5_release_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(backup_req) |-> (acc_done || abort_pulse));

   // R12: an abort cancels the pending backup
   a_r12_abort_drops_backup: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_pulse && $past(backup_req)) |-> !backup_req);

   // R8: the invalidate mask is quiet outside an abort
   a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_pulse |-> (inval_mask == '0));

   // R2: conflict cause needs an incoming request one cycle earlier
   a_r2_conflict_source: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_pulse && abort_cause == 2'b00) |-> $past(snoop_valid));

   // R6: eviction causes need an eviction of the matching kind
   a_r6_evict_source: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_pulse && (abort_cause == 2'b01 || abort_cause == 2'b10))
         |-> ($past(evict_valid) && ($past(evict_incl) == (abort_cause == 2'b10))));

   // R7: explicit cause needs an abort request
   a_r7_explicit_source: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_pulse && abort_cause == 2'b11) |-> $past(abort_req));

   // R1: no spurious pulses on the first cycle out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!abort_pulse && !acc_done && !backup_req));

endmodule

bind txn_set_tracker txn_set_tracker_chk #(.LINES(LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_ready   (acc_ready),
   .acc_done    (acc_done),
   .snoop_valid (snoop_valid),
   .evict_valid (evict_valid),
   .evict_incl  (evict_incl),
   .abort_req   (abort_req),
   .backup_req  (backup_req),
   .abort_pulse (abort_pulse),
   .abort_cause (abort_cause),
   .inval_mask  (inval_mask)
);

// File: tb/txn_set_tracker_tb.sv
module txn_set_tracker_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WAYS  = 4;
   localparam int SET_W = 7;
   localparam int WAY_W = 2;
   localparam int LINES = 512;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid, acc_txn, acc_store, acc_line_mod;
   logic [SET_W-1:0] acc_set;
   logic [WAY_W-1:0] acc_way;
   logic             acc_ready, acc_done;
   logic             snoop_valid, snoop_write;
   logic [SET_W-1:0] snoop_set;
   logic [WAY_W-1:0] snoop_way;
   logic             evict_valid, evict_incl;
   logic [SET_W-1:0] evict_set;
   logic [WAY_W-1:0] evict_way;
   logic             commit, abort_req, backup_ack;
   logic             backup_req;
   logic [SET_W-1:0] backup_set;
   logic [WAY_W-1:0] backup_way;
   logic             abort_pulse;
   logic [1:0]       abort_cause;
   logic [LINES-1:0] inval_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   txn_set_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_txn(acc_txn),
      .acc_store(acc_store), .acc_line_mod(acc_line_mod),
      .acc_set(acc_set), .acc_way(acc_way), .acc_done(acc_done),
      .snoop_valid(snoop_valid), .snoop_write(snoop_write),
      .snoop_set(snoop_set), .snoop_way(snoop_way),
      .evict_valid(evict_valid), .evict_incl(evict_incl),
      .evict_set(evict_set), .evict_way(evict_way),
      .commit(commit), .abort_req(abort_req),
      .backup_req(backup_req), .backup_set(backup_set), .backup_way(backup_way),
      .backup_ack(backup_ack),
      .abort_pulse(abort_pulse), .abort_cause(abort_cause), .inval_mask(inval_mask)
   );

   typedef struct {
      string            tag;
      bit               abort;
      bit [1:0]         cause;
      bit [LINES-1:0]   mask;
      bit               done;
      bit               breq;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;

   // reference state built from the requirements
   bit [LINES-1:0] m_rd = '0;
   bit [LINES-1:0] m_wr = '0;
   bit             m_pend = 1'b0;
   int             m_pidx = 0;

   task automatic clear_inputs();
      acc_valid = 0; acc_txn = 0; acc_store = 0; acc_line_mod = 0;
      acc_set = '0; acc_way = '0;
      snoop_valid = 0; snoop_write = 0; snoop_set = '0; snoop_way = '0;
      evict_valid = 0; evict_incl = 0; evict_set = '0; evict_way = '0;
      commit = 0; abort_req = 0; backup_ack = 0;
   endtask

   task automatic set_acc(bit txn, bit st, bit md, int s, int w);
      acc_valid = 1; acc_txn = txn; acc_store = st; acc_line_mod = md;
      acc_set = SET_W'(s); acc_way = WAY_W'(w);
   endtask

   task automatic set_snoop(bit wr, int s, int w);
      snoop_valid = 1; snoop_write = wr; snoop_set = SET_W'(s); snoop_way = WAY_W'(w);
   endtask

   task automatic set_evict(bit incl, int s, int w);
      evict_valid = 1; evict_incl = incl; evict_set = SET_W'(s); evict_way = WAY_W'(w);
   endtask

   // driver: model one cycle, queue the expected outputs, advance
   task automatic tick(string tag);
      exp_t e;
      int   ai = int'(acc_set) * WAYS + int'(acc_way);
      int   si = int'(snoop_set) * WAYS + int'(snoop_way);
      int   ei = int'(evict_set) * WAYS + int'(evict_way);
      bit   accept = acc_valid && !m_pend;
      bit   conf = snoop_valid && (m_wr[si] || (snoop_write && m_rd[si]));
      bit   ev   = evict_valid && (m_rd[ei] || m_wr[ei]);
      bit   ab   = conf || ev || abort_req;
      bit   fin, need;
      e.tag   = tag;
      e.abort = ab;
      e.cause = !ab ? 2'b00 : conf ? 2'b00 : ev ? (evict_incl ? 2'b10 : 2'b01) : 2'b11;
      e.mask  = ab ? m_wr : '0;
      if (ab || commit) begin m_rd = '0; m_wr = '0; end
      fin  = m_pend && backup_ack && !ab;
      need = accept && acc_txn && acc_store && acc_line_mod && !m_wr[ai];
      if (accept && acc_txn && !acc_store) m_rd[ai] = 1'b1;
      if (accept && acc_txn && acc_store && !need) m_wr[ai] = 1'b1;
      if (fin) m_wr[m_pidx] = 1'b1;
      e.done = (accept && !need) || fin;
      if (need) begin m_pend = 1'b1; m_pidx = ai; end
      else if (ab || fin) m_pend = 1'b0;
      e.breq = m_pend;
      exp_q.push_back(e);
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic chk(bit ok, string tag, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // monitor: compare results a little after each rising edge
   always @(posedge clk) begin
      #3;
      if (exp_q.size() > 0) begin
         exp_t e;
         bit   bad;
         e = exp_q.pop_front();
         bad = 1'b0;
         n_chk++;
         if (abort_pulse !== e.abort) begin
            bad = 1'b1;
            $display("FAIL %s abort_pulse: actual %0b expected %0b", e.tag, abort_pulse, e.abort);
         end
         if (abort_cause !== e.cause) begin
            bad = 1'b1;
            $display("FAIL %s abort_cause: actual %0b expected %0b", e.tag, abort_cause, e.cause);
         end
         if (inval_mask !== e.mask) begin
            bad = 1'b1;
            $display("FAIL %s inval_mask: actual %h expected %h", e.tag, inval_mask, e.mask);
         end
         if (acc_done !== e.done) begin
            bad = 1'b1;
            $display("FAIL %s acc_done: actual %0b expected %0b", e.tag, acc_done, e.done);
         end
         if (backup_req !== e.breq) begin
            bad = 1'b1;
            $display("FAIL %s backup_req: actual %0b expected %0b", e.tag, backup_req, e.breq);
         end
         if (bad) n_fail++;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      clear_inputs();
      repeat (3) @(negedge clk);
      // R1: outputs quiet in and just out of reset
      chk(abort_pulse == 0 && acc_done == 0 && backup_req == 0 && inval_mask == '0,
          "R1 reset outputs", int'(abort_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(acc_ready == 1, "R1 ready after reset", int'(acc_ready), 1);
      set_snoop(1, 0, 0); tick("R1 untracked snoop");

      // R2: read set
      set_acc(1, 0, 0, 5, 1); tick("R2 txn load");
      set_snoop(0, 5, 1);     tick("R2 remote read no conflict");
      set_snoop(1, 5, 1);     tick("R2 remote write conflict");
      tick("R2 idle after abort");

      // R3: write set, no backup on non-modified line
      set_acc(1, 1, 0, 9, 2); tick("R3 txn store");
      set_snoop(0, 9, 2);     tick("R3 remote read conflict");

      // R4: non-transactional accesses leave no mark
      set_acc(0, 0, 0, 3, 0); tick("R4 plain load");
      set_acc(0, 1, 1, 3, 0); tick("R4 plain store");
      set_evict(0, 3, 0);     tick("R4 evict unmarked");
      set_snoop(1, 3, 0);     tick("R4 snoop unmarked");

      // R6: evictions of tracked lines
      set_acc(1, 0, 0, 10, 3); tick("R6 load");
      set_evict(0, 10, 3);     tick("R6 L1 eviction");
      set_acc(1, 0, 0, 10, 3); tick("R6 load again");
      set_evict(1, 10, 3);     tick("R6 inclusion eviction");

      // R7: explicit abort
      set_acc(1, 1, 0, 11, 0); tick("R7 store");
      abort_req = 1;           tick("R7 explicit abort");

      // R5: backup on first store to a modified line
      set_acc(1, 1, 1, 20, 1); tick("R5 store starts backup");
      chk(acc_ready == 0, "R5 ready low while pending", int'(acc_ready), 0);
      chk(backup_set == 7'd20 && backup_way == 2'd1, "R5 backup address",
          int'(backup_set) * WAYS + int'(backup_way), 20 * WAYS + 1);
      set_acc(1, 0, 0, 21, 0); tick("R5 access held off");
      tick("R5 waiting");
      backup_ack = 1;          tick("R5 ack");
      set_acc(1, 1, 1, 20, 1); tick("R5 second store no backup");
      set_snoop(0, 20, 1);     tick("R5 flag set after backup");

      // R9: commit clears silently
      set_acc(1, 1, 0, 22, 2); tick("R9 store");
      commit = 1;              tick("R9 commit");
      set_snoop(1, 22, 2);     tick("R9 snoop after commit");

      // R10: clear first, access belongs to the next transaction
      set_acc(1, 0, 0, 30, 0); commit = 1; tick("R10 load with commit");
      set_snoop(1, 30, 0);     tick("R10 load survived clear");
      set_acc(1, 1, 0, 31, 1); abort_req = 1; tick("R10 store with abort");
      abort_req = 1;           tick("R10 mask shows new store");

      // R11: priority of coincident causes
      set_acc(1, 1, 0, 40, 0); tick("R11 store");
      set_snoop(1, 40, 0); set_evict(1, 40, 0); abort_req = 1; tick("R11 conflict wins");
      set_acc(1, 0, 0, 41, 0); tick("R11 load");
      set_evict(0, 41, 0); abort_req = 1; tick("R11 eviction over explicit");

      // R12: abort during a pending backup
      set_acc(1, 0, 0, 51, 2); tick("R12 load");
      set_acc(1, 1, 1, 50, 3); tick("R12 store pending");
      set_snoop(1, 51, 2);     tick("R12 abort kills store");
      backup_ack = 1;          tick("R12 late ack ignored");
      set_snoop(0, 50, 3);     tick("R12 no write flag");

      // R8: mask carries exactly the write set
      set_acc(1, 1, 0, 60, 0);  tick("R8 store a");
      set_acc(1, 1, 0, 127, 3); tick("R8 store b");
      set_acc(1, 0, 0, 62, 1);  tick("R8 load");
      abort_req = 1;            tick("R8 mask two lines");
      abort_req = 1;            tick("R8 flags cleared");
      tick("R8 idle");

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule